// File: doc/BRIEF.md
# Radix-23 Word Arithmetic Unit

This unit does arithmetic on words of four base-23 digits. Each digit is held in its own 5-bit binary field with a value from 0 to 22. It offers six operations: add, subtract, compare, multiply, floor divide and remainder. Every result wraps modulo 23^4, so a word holds values from 0 to 279,840. Every operation also produces three flags: zero, negative and carry.

Add and subtract do not convert the words to binary. Each digit stage adds or subtracts on its own and passes a base-23 carry or borrow to the next stage. Add, subtract and compare finish one cycle after they are accepted. Multiply, divide and remainder run over several cycles in a sequencer. A caller raises `start` for one cycle with the operation code and both operands. It then waits for the one-cycle `done` pulse. `busy` is high while a multi-cycle operation is in progress.

Top module: `q23_alu`

## Requirements
- R1: A word has 4 digit fields of 5 bits each. Digit i sits at bits [5i+4:5i], and digit 0 is the least significant. The word's value is the sum of d_i·23^i. Every digit of `result` is always in the range 0 to 22.
- R2: ADD returns (a+b) mod 23^4. C is 1 exactly when a+b ≥ 23^4, which is a carry out of the top digit. `done` is high in the cycle after the accepted start.
- R3: SUB returns (a−b) mod 23^4. C is 1 exactly when a < b, which is a borrow out of the top digit. `done` is high in the cycle after the accepted start.
- R4: CMP sets Z, N and C exactly as SUB would. It leaves `result` unchanged. `done` is high in the cycle after the accepted start.
- R5: Z is 1 exactly when the value the flags are taken from is zero. N is 1 exactly when that value's top digit is 12 or more. For CMP that value is the difference. For all other operations it is the new result.
- R6: MUL returns the product mod 23^4. C is 1 exactly when the full product is 23^4 or more.
- R7: DIV returns floor(a/b) with C equal to 0 when b is not zero.
- R8: MOD returns a mod b with C equal to 0 when b is not zero.
- R9: DIV or MOD with b equal to zero returns the all-zero word, sets C to 1 and Z to 1, and still completes with a `done` pulse.
- R10: After reset, `result` and all flags are 0, and `busy` and `done` are low. An accepted MUL, DIV or MOD raises `busy` from the next cycle. `busy` stays high until the cycle in which `done` pulses, and `busy` is low in that cycle. A `start` that arrives while `busy` is high is ignored.
- R11: The operation codes are ADD=0, SUB=1, CMP=2, MUL=3, DIV=4 and MOD=5. Codes 6 and 7 are reserved. A reserved code gives a `done` pulse in the next cycle and leaves `result` and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new operation |
| op | input | 3 | Operation code (see R11) |
| a_word | input | 20 | First operand, four base-23 digits |
| b_word | input | 20 | Second operand, four base-23 digits |
| busy | output | 1 | A multi-cycle operation is in progress |
| done | output | 1 | One-cycle pulse: the result and flags are updated |
| result | output | 20 | Result word, four base-23 digits |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag (top digit ≥ 12) |
| flag_c | output | 1 | Carry, borrow, overflow or divide-by-zero flag |

## Verification
The assertions take it for granted that every operand digit is in the range 0 to 22. Under that assumption the digit-range property on `result` and the one-cycle completion properties are sound. The bench builds every operand from an integer below 23^4 through its own digit encoder, so no illegal digit ever reaches the unit. The handshake properties assume that `start` is only sampled at clock edges. The bench drives `start` on falling edges, and it raises a second `start` during `busy` only as a deliberate test that the request is ignored.

// File: rtl/q23_pkg.sv
package q23_pkg;
   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_CMP = 3'd2,
      OP_MUL = 3'd3,
      OP_DIV = 3'd4,
      OP_MOD = 3'd5
   } q23_op_e;
endpackage

// File: rtl/q23_digit_chain.sv
// Ripple chain of base-23 digit adders or subtractors; SUBTRACT picks the variant.
module q23_digit_chain #(
   parameter int RADIX    = 23,
   parameter int DW       = 5,
   parameter int NDIG     = 4,
   parameter bit SUBTRACT = 1'b0
) (
   input  logic [NDIG*DW-1:0] a_i,
   input  logic [NDIG*DW-1:0] b_i,
   output logic [NDIG*DW-1:0] y_o,
   output logic               c_o
);
   logic [NDIG:0] cy;
   assign cy[0] = 1'b0;

   for (genvar i = 0; i < NDIG; i++) begin : g_dig
      if (SUBTRACT) begin : g_sub
         logic [DW+1:0] diff;
         assign diff = {2'b00, a_i[i*DW +: DW]} - {2'b00, b_i[i*DW +: DW]}
                       - {{(DW+1){1'b0}}, cy[i]};
         assign cy[i+1] = diff[DW+1];
         assign y_o[i*DW +: DW] = diff[DW+1] ? DW'(diff + (DW+2)'(RADIX))
                                             : diff[DW-1:0];
      end else begin : g_add
         logic [DW:0] sum;
         assign sum = {1'b0, a_i[i*DW +: DW]} + {1'b0, b_i[i*DW +: DW]}
                      + {{DW{1'b0}}, cy[i]};
         assign cy[i+1] = (sum >= (DW+1)'(RADIX));
         assign y_o[i*DW +: DW] = cy[i+1] ? DW'(sum - (DW+1)'(RADIX))
                                          : sum[DW-1:0];
      end
   end

   assign c_o = cy[NDIG];
endmodule

// File: rtl/q23_seq_core.sv
// Multi-cycle engine: digit-serial multiply, bit-serial restoring divide.
module q23_seq_core #(
   parameter int RADIX = 23,
   parameter int DW    = 5,
   parameter int NDIG  = 4,
   parameter int VW    = 19
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic               mul_i,
   input  logic               mod_i,
   input  logic [VW-1:0]      a_bin_i,
   input  logic [VW-1:0]      b_bin_i,
   input  logic [NDIG*DW-1:0] b_word_i,
   output logic               fin_o,
   output logic [VW-1:0]      res_o,
   output logic               c_o
);
   localparam int PW   = 2 * VW;
   localparam int CW   = $clog2(VW + 1);
   localparam int MODV = RADIX ** NDIG;

   logic               busy_r, fin_r, mul_r, mod_r, dz_r;
   logic [CW-1:0]      cnt;
   logic [PW-1:0]      acc;
   logic [VW-1:0]      a_r, b_r, rem, quo;
   logic [NDIG*DW-1:0] bw_r;
   logic [DW-1:0]      cur_dig;
   logic [VW:0]        trial;
   logic               q_bit;
   logic [VW-1:0]      rem_nx;

   // multiplier digit for this step, most significant first
   always_comb begin
      cur_dig = '0;
      for (int k = 0; k < NDIG; k++)
         if (int'(cnt) == k + 1) cur_dig = bw_r[k*DW +: DW];
   end

   assign trial  = {rem, quo[VW-1]};
   assign q_bit  = (trial >= {1'b0, b_r});
   assign rem_nx = q_bit ? VW'(trial - {1'b0, b_r}) : trial[VW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_r <= 1'b0; fin_r <= 1'b0; mul_r <= 1'b0; mod_r <= 1'b0; dz_r <= 1'b0;
         cnt <= '0; acc <= '0; a_r <= '0; b_r <= '0; rem <= '0; quo <= '0; bw_r <= '0;
      end else begin
         fin_r <= 1'b0;
         if (load_i) begin
            busy_r <= 1'b1;
            mul_r  <= mul_i;
            mod_r  <= mod_i;
            dz_r   <= !mul_i && (b_bin_i == '0);
            a_r    <= a_bin_i;
            b_r    <= b_bin_i;
            bw_r   <= b_word_i;
            acc    <= '0;
            rem    <= '0;
            quo    <= a_bin_i;
            if (mul_i)               cnt <= CW'(NDIG);
            else if (b_bin_i == '0)  cnt <= CW'(1);
            else                     cnt <= CW'(VW);
         end else if (busy_r) begin
            if (mul_r) begin
               acc <= acc * PW'(RADIX) + PW'(a_r) * PW'(cur_dig);
            end else if (!dz_r) begin
               rem <= rem_nx;
               quo <= {quo[VW-2:0], q_bit};
            end
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) begin
               busy_r <= 1'b0;
               fin_r  <= 1'b1;
            end
         end
      end
   end

   assign fin_o = fin_r;
   assign res_o = mul_r ? VW'(acc % PW'(MODV)) :
                  dz_r  ? '0 :
                  mod_r ? rem : quo;
   assign c_o   = mul_r ? (acc >= PW'(MODV)) : dz_r;
endmodule

// File: rtl/q23_alu.sv
module q23_alu
   import q23_pkg::*;
#(
   parameter int RADIX = 23,
   parameter int DW    = 5,
   parameter int NDIG  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [2:0]         op,
   input  logic [NDIG*DW-1:0] a_word,
   input  logic [NDIG*DW-1:0] b_word,
   output logic               busy,
   output logic               done,
   output logic [NDIG*DW-1:0] result,
   output logic               flag_z,
   output logic               flag_n,
   output logic               flag_c
);
   localparam int WW     = NDIG * DW;
   localparam int MODV   = RADIX ** NDIG;
   localparam int VW     = $clog2(MODV);
   localparam int NEG_TH = (RADIX + 1) / 2;

   if (RADIX < 2 || RADIX > (1 << DW)) begin : g_bad_radix
      $error("q23_alu: RADIX does not fit in a DW-bit digit");
   end
   if (NDIG < 2) begin : g_bad_ndig
      $error("q23_alu: NDIG must be at least 2");
   end

   function automatic logic [VW-1:0] to_bin(input logic [WW-1:0] w);
      logic [VW-1:0] v;
      v = '0;
      for (int i = NDIG - 1; i >= 0; i--)
         v = v * VW'(RADIX) + VW'(w[i*DW +: DW]);
      return v;
   endfunction

   function automatic logic [WW-1:0] to_word(input logic [VW-1:0] v);
      logic [WW-1:0] w;
      logic [VW-1:0] t;
      t = v;
      for (int i = 0; i < NDIG; i++) begin
         w[i*DW +: DW] = DW'(t % VW'(RADIX));
         t = t / VW'(RADIX);
      end
      return w;
   endfunction

   function automatic logic neg_of(input logic [WW-1:0] w);
      return w[WW-1 -: DW] >= DW'(NEG_TH);
   endfunction

   logic [WW-1:0] add_y, sub_y, core_word, res_q;
   logic          add_c, sub_c, core_c, core_fin;
   logic [VW-1:0] core_res;
   logic          busy_q, done_q, z_q, n_q, c_q;
   logic          is_seq, core_load;

   q23_digit_chain #(.RADIX(RADIX), .DW(DW), .NDIG(NDIG), .SUBTRACT(1'b0)) u_add (
      .a_i(a_word), .b_i(b_word), .y_o(add_y), .c_o(add_c));

   q23_digit_chain #(.RADIX(RADIX), .DW(DW), .NDIG(NDIG), .SUBTRACT(1'b1)) u_sub (
      .a_i(a_word), .b_i(b_word), .y_o(sub_y), .c_o(sub_c));

   assign is_seq    = (op == OP_MUL) || (op == OP_DIV) || (op == OP_MOD);
   assign core_load = start && !busy_q && is_seq;

   q23_seq_core #(.RADIX(RADIX), .DW(DW), .NDIG(NDIG), .VW(VW)) u_core (
      .clk(clk), .rst_n(rst_n), .load_i(core_load),
      .mul_i(op == OP_MUL), .mod_i(op == OP_MOD),
      .a_bin_i(to_bin(a_word)), .b_bin_i(to_bin(b_word)), .b_word_i(b_word),
      .fin_o(core_fin), .res_o(core_res), .c_o(core_c));

   assign core_word = to_word(core_res);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0; done_q <= 1'b0; res_q <= '0;
         z_q <= 1'b0; n_q <= 1'b0; c_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start && !busy_q) begin
            case (op)
               OP_ADD: begin
                  res_q <= add_y; z_q <= (add_y == '0); n_q <= neg_of(add_y);
                  c_q <= add_c; done_q <= 1'b1;
               end
               OP_SUB: begin
                  res_q <= sub_y; z_q <= (sub_y == '0); n_q <= neg_of(sub_y);
                  c_q <= sub_c; done_q <= 1'b1;
               end
               OP_CMP: begin
                  z_q <= (sub_y == '0); n_q <= neg_of(sub_y);
                  c_q <= sub_c; done_q <= 1'b1;
               end
               OP_MUL, OP_DIV, OP_MOD: busy_q <= 1'b1;
               default: done_q <= 1'b1;
            endcase
         end else if (busy_q && core_fin) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            res_q  <= core_word;
            z_q    <= (core_word == '0);
            n_q    <= neg_of(core_word);
            c_q    <= core_c;
         end
      end
   end

   assign busy   = busy_q;
   assign done   = done_q;
   assign result = res_q;
   assign flag_z = z_q;
   assign flag_n = n_q;
   assign flag_c = c_q;
endmodule

// File: rtl/q23_alu_chk.sv
module q23_alu_chk #(
   parameter int RADIX = 23,
   parameter int DW    = 5,
   parameter int NDIG  = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic [2:0]         op,
   input logic               busy,
   input logic               done,
   input logic [NDIG*DW-1:0] result
);
   for (genvar i = 0; i < NDIG; i++) begin : g_rng
      p_digit_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
         result[i*DW +: DW] < DW'(RADIX));
   end

   // R2, R3, R4: fast operations finish in one cycle
   p_fast_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && op <= 3'd2) |=> done);

   p_cmp_keeps_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && op == 3'd2) |=> $stable(result));

   p_seq_enter_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && op >= 3'd3 && op <= 3'd5) |=> (busy && !done));

   p_busy_until_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (busy || done));

   p_done_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_reserved_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && op >= 3'd6) |=> (done && $stable(result)));
endmodule

bind q23_alu q23_alu_chk #(.RADIX(RADIX), .DW(DW), .NDIG(NDIG)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .op(op),
   .busy(busy), .done(done), .result(result));

// File: tb/tb_q23_alu.sv
module tb_q23_alu;
   localparam int RADIX = 23;
   localparam int DW    = 5;
   localparam int NDIG  = 4;
   localparam int WW    = NDIG * DW;
   localparam int M     = 279841;
   localparam int TOPW  = 12167;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [2:0]    op = 3'd0;
   logic [WW-1:0] a_word = '0, b_word = '0;
   logic          busy, done, flag_z, flag_n, flag_c;
   logic [WW-1:0] result;

   always #10 clk = ~clk;

   q23_alu #(.RADIX(RADIX), .DW(DW), .NDIG(NDIG)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op),
      .a_word(a_word), .b_word(b_word), .busy(busy), .done(done),
      .result(result), .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c));

   typedef struct {
      logic [WW-1:0] res;
      bit            z, n, c;
      string         tag;
   } exp_t;

   exp_t sb[$];
   int   n_tests = 0;
   int   n_fail  = 0;
   int   m_res = 0;
   bit   m_z = 0, m_n = 0, m_c = 0;

   function automatic logic [WW-1:0] enc(input int v);
      logic [WW-1:0] w;
      int t = v;
      for (int i = 0; i < NDIG; i++) begin
         w[i*DW +: DW] = DW'(t % RADIX);
         t = t / RADIX;
      end
      return w;
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R10", "done without accepted request", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            n_tests++;
            if (result !== e.res || flag_z !== e.z || flag_n !== e.n || flag_c !== e.c) begin
               n_fail++;
               $display("FAIL %s: actual res=%h z%0d n%0d c%0d expected res=%h z%0d n%0d c%0d",
                        e.tag, result, flag_z, flag_n, flag_c, e.res, e.z, e.n, e.c);
            end
         end
      end
   end

   // driver: computes the expected item, pushes it, drives one request
   task automatic issue(input int opc, input int a, input int b,
                        input string tag, input bit inject = 1'b0);
      exp_t   e;
      int     fv;
      longint p;
      bit     cc;
      fv = m_res; cc = m_c;
      case (opc)
         0: begin fv = (a + b) % M; cc = (a + b) >= M; m_res = fv; end
         1: begin fv = (a - b + M) % M; cc = (a < b); m_res = fv; end
         2: begin fv = (a - b + M) % M; cc = (a < b); end
         3: begin p = longint'(a) * longint'(b); fv = int'(p % M); cc = (p >= M); m_res = fv; end
         4: begin fv = (b == 0) ? 0 : a / b; cc = (b == 0); m_res = fv; end
         5: begin fv = (b == 0) ? 0 : a % b; cc = (b == 0); m_res = fv; end
         default: ;
      endcase
      if (opc <= 5) begin
         m_z = (fv == 0);
         m_n = (fv / TOPW) >= 12;
         m_c = cc;
      end
      e.res = enc(m_res); e.z = m_z; e.n = m_n; e.c = m_c; e.tag = tag;
      sb.push_back(e);

      start = 1'b1; op = 3'(opc); a_word = enc(a); b_word = enc(b);
      @(negedge clk);
      start = 1'b0;
      if (opc <= 2 || opc >= 6)
         chk(done === 1'b1, tag, "done one cycle after start", int'(done), 1);
      if (inject && opc >= 3 && opc <= 5) begin
         chk(busy === 1'b1, "R10", "busy after multi-cycle start", int'(busy), 1);
         start = 1'b1; op = 3'd0; a_word = enc(1); b_word = enc(1);
         @(negedge clk);
         start = 1'b0;
      end
      while (!done) @(negedge clk);
      chk(busy === 1'b0, "R10", "busy low during done", int'(busy), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int seed;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk(result === '0, "R10", "result after reset", int'(result), 0);
      chk({flag_z, flag_n, flag_c} === 3'b000, "R10", "flags after reset",
          int'({flag_z, flag_n, flag_c}), 0);
      chk({busy, done} === 2'b00, "R10", "busy/done after reset", int'({busy, done}), 0);

      issue(0, 5, 7, "R2 small add");
      issue(0, M - 1, 1, "R2 full carry chain wrap");
      issue(0, M - 1, M - 1, "R2 double max");
      issue(0, 11 * TOPW + 22 * 529, 0, "R5 N boundary low");
      issue(0, 12 * TOPW, 0, "R5 N boundary high");
      issue(1, 10, 3, "R3 small sub");
      issue(1, 3, 10, "R3 borrow wrap");
      issue(1, 4321, 4321, "R3 equal gives zero");
      issue(1, 0, M - 1, "R3 zero minus max");
      issue(2, 5, 9, "R4 cmp less");
      issue(2, 777, 777, "R4 cmp equal");
      issue(3, 123, 456, "R6 small product");
      issue(3, 529, 529, "R6 exact overflow");
      issue(3, M - 1, M - 1, "R6 max product");
      issue(4, M - 1, 7, "R7 divide");
      issue(4, 5, 9, "R7 quotient zero");
      issue(5, M - 1, 1000, "R8 remainder");
      issue(5, 1000, M - 1, "R8 small dividend");
      issue(4, 12345, 0, "R9 divide by zero");
      issue(5, 12345, 0, "R9 modulo by zero");
      issue(0, 9, 9, "R2 before reserved");
      issue(6, 1, 2, "R11 reserved code 6");
      issue(7, 3, 4, "R11 reserved code 7");
      issue(3, 1000, 1000, "R10 start ignored while busy", 1'b1);
      repeat (4) @(negedge clk);

      seed = 17;
      for (int k = 0; k < 24; k++) begin
         int ra, rb, ro;
         seed = (seed * 1103515 + 12345) & 32'h7fffffff;
         ra = seed % M;
         seed = (seed * 1103515 + 12345) & 32'h7fffffff;
         rb = seed % M;
         ro = k % 6;
         if (ro >= 4 && (k % 4) == 0) rb = rb % 300;
         issue(ro, ra, rb, "R6 R7 R8 R2 R3 mixed");
      end

      repeat (5) @(negedge clk);
      chk(sb.size() == 0, "R10", "pending expected items", sb.size(), 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule